// File: doc/BRIEF.md
# Receive Channel Bring-Up Sequencer

This block brings up the receive half of a serial transceiver channel after power-up or after a user restart request. It runs on a free-running stable clock. It owns the channel receive reset, the user-ready handshake, an optional PLL reset and a phase-alignment request. Along the way it waits for PLL lock, for a stable recovered clock, for the channel's reset-done flag, for phase alignment (only when the elastic buffer is bypassed) and for data-valid. Data-valid must then hold for a qualification window, which is followed by a short settling delay. After that the block raises its done flag.

Every wait has a timeout. A timeout, or a loss of data-valid inside the qualification window, counts as a failed attempt. On a failed attempt the block puts the channel back into receive reset, bumps a saturating retry counter and starts again from the PLL-lock wait. Loss of the PLL reference clock sends the block straight back to its initial reset state.

All time intervals are given in nanoseconds and converted to stable-clock cycles at elaboration. All status inputs pass through two-flop synchronizers before the state machine reads them. The retry counter width is a parameter in the range 2 to 8.

Top module: `rx_reset_seq`

## Requirements
- R1: After rst_ni deasserts, or while the sequencer is in its initial state, chan_rst_o=1, user_rdy_o=0, done_o=0 and retry_cnt_o=0. When OWN_PLL=1, pll_reset_o is 1 for the first PLL_RST_NS of the initial state and 0 afterwards. When OWN_PLL=0, pll_reset_o stays 0.
- R2: chan_rst_o stays 1 for as long as pll_lock_i is 0, and falls within a few cycles after pll_lock_i rises.
- R3: user_rdy_o rises only once the recovered clock is stable. With CLK_MON=0, stability is declared RECCLK_NS after chan_rst_o falls, and the count restarts whenever chan_rst_o is 1. With CLK_MON=1, stability follows recclk_stable_i.
- R4: With USRCLK_FROM_TX=1, user_rdy_o waits for tx_user_rdy_i=1. With USRCLK_FROM_TX=0, tx_user_rdy_i is ignored.
- R5: With BUF_BYPASS=1, run_phalign_o goes to 1 after channel reset-done and returns to 0 once phalign_done_i=1. With BUF_BYPASS=0, run_phalign_o stays 0 and alignment counts as already done.
- R6: done_o rises no sooner than DV_WIN_NS+SETTLE_NS after data_valid_i rises, and at most a few cycles later.
- R7: If data_valid_i drops during the qualification window, chan_rst_o returns to 1, done_o stays 0 and retry_cnt_o increases by 1.
- R8: A wait that exceeds WAIT_TMO_NS counts as a failure: chan_rst_o returns to 1, user_rdy_o falls and retry_cnt_o increases by 1.
- R9: retry_cnt_o saturates at its all-ones value and does not wrap.
- R10: refclk_lost_i=1 forces the initial state within a few cycles: done_o=0, chan_rst_o=1, and pll_reset_o=1 when OWN_PLL=1. retry_cnt_o is left unchanged.
- R11: A one-cycle start_i restarts the sequence from the initial state and clears retry_cnt_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running stable clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart request, one cycle, synchronous to clk_i |
| pll_lock_i | input | 1 | PLL locked (asynchronous) |
| refclk_lost_i | input | 1 | PLL reference clock lost (asynchronous) |
| chan_rst_done_i | input | 1 | Channel receive reset complete (asynchronous) |
| phalign_done_i | input | 1 | Phase alignment complete (asynchronous) |
| data_valid_i | input | 1 | Receive data valid (asynchronous) |
| tx_user_rdy_i | input | 1 | Transmit side user-ready (asynchronous) |
| recclk_stable_i | input | 1 | Recovered-clock monitor result, used when CLK_MON=1 |
| pll_reset_o | output | 1 | PLL reset, driven only when OWN_PLL=1 |
| chan_rst_o | output | 1 | Channel receive reset |
| user_rdy_o | output | 1 | Receive user clock usable |
| run_phalign_o | output | 1 | Phase alignment request |
| done_o | output | 1 | Receive bring-up complete |
| retry_cnt_o | output | RETRY_W | Saturating count of failed attempts |

## Verification
The assertions assume three things about the inputs. First, start_i is already synchronous to clk_i. Second, every asynchronous status input holds each level for at least two stable-clock cycles, so the synchronizers pass it through intact. Third, the reference-clock loss flag is a level and not a glitch.

The stimulus meets these assumptions. It changes inputs one nanosecond after a clock edge and holds each level for many cycles. It raises start_i for exactly one cycle. It pulses the reference-loss flag for several cycles, long enough to be synchronized.

// File: rtl/rxrst_pkg.sv
`timescale 1ns/1ps
package rxrst_pkg;
  typedef enum logic [3:0] {
    ST_INIT, ST_LOCK, ST_RECCLK, ST_RSTDONE, ST_PHALIGN,
    ST_DVWAIT, ST_QUAL, ST_SETTLE, ST_DONE
  } rx_state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/rxrst_sync.sv
`timescale 1ns/1ps
module rxrst_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rxrst_timer.sv
`timescale 1ns/1ps
module rxrst_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  // hit after lim_i cycles in the current wait
  assign hit_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/rxrst_recclk.sv
`timescale 1ns/1ps
module rxrst_recclk #(
  parameter int unsigned LIM = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chan_rst_i,
  output logic stable_o
);
  localparam int CW = $clog2(LIM + 1);
  logic [CW-1:0] cnt_q;
  logic          stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (chan_rst_i) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      if (cnt_q == CW'(LIM - 1)) stable_q <= 1'b1;
      else                       cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign stable_o = stable_q;

  AST_STABLE_OUT_OF_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_q) |-> $past(!chan_rst_i)) else $error("stable rose under reset"); // R3
endmodule

// File: rtl/rx_reset_seq.sv
`timescale 1ns/1ps
module rx_reset_seq #(
  parameter int unsigned CLK_PERIOD_NS  = 8,
  parameter int unsigned PLL_RST_NS     = 1000,
  parameter int unsigned WAIT_TMO_NS    = 1000000,
  parameter int unsigned RECCLK_NS      = 20000,
  parameter int unsigned DV_WIN_NS      = 100000,
  parameter int unsigned SETTLE_NS      = 1000,
  parameter bit          BUF_BYPASS     = 1'b0,
  parameter bit          USRCLK_FROM_TX = 1'b0,
  parameter bit          CLK_MON        = 1'b0,
  parameter bit          OWN_PLL        = 1'b1,
  parameter int          RETRY_W        = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               pll_lock_i,
  input  logic               refclk_lost_i,
  input  logic               chan_rst_done_i,
  input  logic               phalign_done_i,
  input  logic               data_valid_i,
  input  logic               tx_user_rdy_i,
  input  logic               recclk_stable_i,
  output logic               pll_reset_o,
  output logic               chan_rst_o,
  output logic               user_rdy_o,
  output logic               run_phalign_o,
  output logic               done_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  import rxrst_pkg::*;

  localparam int unsigned RST_CYC    = ns2cyc(PLL_RST_NS, CLK_PERIOD_NS);
  localparam int unsigned TMO_CYC    = ns2cyc(WAIT_TMO_NS, CLK_PERIOD_NS);
  localparam int unsigned RECCLK_CYC = ns2cyc(RECCLK_NS, CLK_PERIOD_NS);
  localparam int unsigned DV_CYC     = ns2cyc(DV_WIN_NS, CLK_PERIOD_NS);
  localparam int unsigned SETTLE_CYC = ns2cyc(SETTLE_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_A      = (RST_CYC > TMO_CYC) ? RST_CYC : TMO_CYC;
  localparam int unsigned MAX_B      = (DV_CYC > SETTLE_CYC) ? DV_CYC : SETTLE_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int          CNT_W      = $clog2(MAX_CYC + 1);

  // synchronized status
  logic [6:0] sync_s;
  logic lock_s, lost_s, rst_done_s, phalign_s, dv_s, tx_s, mon_s;

  rxrst_sync #(.W(7)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pll_lock_i, refclk_lost_i, chan_rst_done_i, phalign_done_i,
             data_valid_i, tx_user_rdy_i, recclk_stable_i}),
    .q_o   (sync_s)
  );
  assign {lock_s, lost_s, rst_done_s, phalign_s, dv_s, tx_s, mon_s} = sync_s;

  rx_state_e        state_q, state_d;
  logic             fail, clr, hit;
  logic [CNT_W-1:0] lim;
  logic             cnt_stable, recclk_ok, tx_ok;
  logic [RETRY_W-1:0] retry_q;
  logic             pll_rst_q, chan_rst_q, rdy_q, phal_q, done_q;

  // recovered-clock stability source
  if (CLK_MON) begin : g_mon
    assign cnt_stable = 1'b0;
  end else begin : g_cnt
    rxrst_recclk #(.LIM(RECCLK_CYC)) u_recclk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .chan_rst_i(chan_rst_q),
      .stable_o  (cnt_stable)
    );
  end
  assign recclk_ok = CLK_MON ? (mon_s & ~chan_rst_q) : cnt_stable;
  assign tx_ok     = USRCLK_FROM_TX ? tx_s : 1'b1;

  always_comb begin
    unique case (state_q)
      ST_INIT:   lim = CNT_W'(RST_CYC);
      ST_QUAL:   lim = CNT_W'(DV_CYC);
      ST_SETTLE: lim = CNT_W'(SETTLE_CYC);
      default:   lim = CNT_W'(TMO_CYC);
    endcase
  end

  always_comb begin
    state_d = state_q;
    fail    = 1'b0;
    unique case (state_q)
      ST_INIT:    if (hit) state_d = ST_LOCK;
      ST_LOCK:    if (lock_s) state_d = ST_RECCLK;
                  else if (hit) fail = 1'b1;
      ST_RECCLK:  if (recclk_ok && tx_ok) state_d = ST_RSTDONE;
                  else if (hit) fail = 1'b1;
      ST_RSTDONE: if (rst_done_s) state_d = BUF_BYPASS ? ST_PHALIGN : ST_DVWAIT;
                  else if (hit) fail = 1'b1;
      ST_PHALIGN: if (phalign_s) state_d = ST_DVWAIT;
                  else if (hit) fail = 1'b1;
      ST_DVWAIT:  if (dv_s) state_d = ST_QUAL;
                  else if (hit) fail = 1'b1;
      ST_QUAL:    if (!dv_s) fail = 1'b1;
                  else if (hit) state_d = ST_SETTLE;
      ST_SETTLE:  if (hit) state_d = ST_DONE;
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_INIT;
    endcase
    if (fail) state_d = ST_LOCK;
    if (start_i || lost_s) begin
      state_d = ST_INIT;
      fail    = 1'b0;
    end
  end

  assign clr = (state_d != state_q) | fail | start_i | lost_s;

  rxrst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .lim_i (lim),
    .hit_o (hit)
  );

  // state and glitch-free registered outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_INIT;
      pll_rst_q  <= OWN_PLL;
      chan_rst_q <= 1'b1;
      rdy_q      <= 1'b0;
      phal_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      pll_rst_q  <= OWN_PLL && (state_d == ST_INIT);
      chan_rst_q <= (state_d == ST_INIT) || (state_d == ST_LOCK);
      rdy_q      <= !((state_d == ST_INIT) || (state_d == ST_LOCK) || (state_d == ST_RECCLK));
      phal_q     <= (state_d == ST_PHALIGN);
      done_q     <= (state_d == ST_DONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    retry_q <= '0;
    else if (start_i)               retry_q <= '0;
    else if (fail && retry_q != '1) retry_q <= retry_q + 1'b1;
  end

  assign pll_reset_o   = pll_rst_q;
  assign chan_rst_o    = chan_rst_q;
  assign user_rdy_o    = rdy_q;
  assign run_phalign_o = phal_q;
  assign done_o        = done_q;
  assign retry_cnt_o   = retry_q;

  AST_RDY_UNDER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |-> !user_rdy_o && !done_o) else $error("ready under reset"); // R1
  AST_RELEASE_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chan_rst_o) |-> $past(lock_s)) else $error("reset released unlocked"); // R2
  AST_RDY_NEEDS_RECCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_rdy_o) |-> $past(recclk_ok)) else $error("ready before stable"); // R3
  AST_RDY_NEEDS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_rdy_o) |-> $past(tx_ok)) else $error("ready before tx ready"); // R4
  AST_PHALIGN_AFTER_RSTDONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_phalign_o) |-> $past(rst_done_s)) else $error("align too early"); // R5
  AST_DONE_NEEDS_DV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(dv_s)) else $error("done without data valid"); // R6
  AST_RETRY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!start_i) && (retry_q != $past(retry_q))) |-> (retry_q == $past(retry_q) + 1'b1))
    else $error("retry jumped"); // R7
  AST_FAIL_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail |=> chan_rst_o) else $error("failure without reset"); // R8
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_q == '1 && !start_i) |=> retry_q == '1) else $error("retry wrapped"); // R9
  AST_REFCLK_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_s |=> chan_rst_o && !done_o) else $error("refclk loss ignored"); // R10
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> retry_q == '0 && chan_rst_o) else $error("start ignored"); // R11
endmodule

// File: tb/rx_reset_seq_tb.sv
`timescale 1ns/1ps
module rx_reset_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, lock, lost, rdone, phdone, dv, txrdy, mon;
  logic pllr_a, crst_a, rdy_a, phal_a, done_a;
  logic pllr_b, crst_b, rdy_b, phal_b, done_b;
  logic [1:0] retry_a, retry_b;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rx_reset_seq #(.CLK_PERIOD_NS(20), .PLL_RST_NS(100), .WAIT_TMO_NS(2000),
    .RECCLK_NS(400), .DV_WIN_NS(1000), .SETTLE_NS(200), .BUF_BYPASS(1'b1),
    .USRCLK_FROM_TX(1'b1), .CLK_MON(1'b0), .OWN_PLL(1'b1), .RETRY_W(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pll_lock_i(lock),
    .refclk_lost_i(lost), .chan_rst_done_i(rdone), .phalign_done_i(phdone),
    .data_valid_i(dv), .tx_user_rdy_i(txrdy), .recclk_stable_i(mon),
    .pll_reset_o(pllr_a), .chan_rst_o(crst_a), .user_rdy_o(rdy_a),
    .run_phalign_o(phal_a), .done_o(done_a), .retry_cnt_o(retry_a));

  rx_reset_seq #(.CLK_PERIOD_NS(20), .PLL_RST_NS(100), .WAIT_TMO_NS(2000),
    .RECCLK_NS(400), .DV_WIN_NS(1000), .SETTLE_NS(200), .BUF_BYPASS(1'b0),
    .USRCLK_FROM_TX(1'b0), .CLK_MON(1'b1), .OWN_PLL(1'b0), .RETRY_W(2)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pll_lock_i(lock),
    .refclk_lost_i(lost), .chan_rst_done_i(rdone), .phalign_done_i(phdone),
    .data_valid_i(dv), .tx_user_rdy_i(txrdy), .recclk_stable_i(mon),
    .pll_reset_o(pllr_b), .chan_rst_o(crst_b), .user_rdy_o(rdy_b),
    .run_phalign_o(phal_b), .done_o(done_b), .retry_cnt_o(retry_b));

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic restart(logic l, logic rd, logic ph, logic d, logic tx, logic m);
    rst_n = 1'b0; start = 1'b0; lost = 1'b0;
    lock = l; rdone = rd; phdone = ph; dv = d; txrdy = tx; mon = m;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic wait_rdy_a();
    for (int i = 0; i < 100 && !rdy_a; i++) tick(1);
  endtask

  task automatic t_reset_state();
    restart(1, 1, 1, 0, 1, 1);
    chk("R1", "chan_rst_a", crst_a, 1);
    chk("R1", "user_rdy_a", rdy_a, 0);
    chk("R1", "done_a", done_a, 0);
    chk("R1", "retry_a", retry_a, 0);
    chk("R1", "pll_reset_a", pllr_a, 1);
    chk("R1", "pll_reset_b", pllr_b, 0);
    tick(8);
    chk("R1", "pll_reset_a after init", pllr_a, 0);
  endtask

  task automatic t_lock_gate();
    int n = 0;
    restart(0, 1, 1, 0, 1, 1);
    tick(60);
    chk("R2", "chan_rst_a while unlocked", crst_a, 1);
    lock = 1'b1;
    while (crst_a && n < 20) begin tick(1); n++; end
    chk_rng("R2", "cycles lock->release", n, 1, 6);
  endtask

  task automatic t_recclk();
    int n = 0;
    restart(1, 1, 1, 0, 1, 0);
    for (int i = 0; i < 40 && crst_a; i++) tick(1);
    while (!rdy_a && n < 60) begin tick(1); n++; end
    chk_rng("R3", "release->ready cycles", n, 20, 24);
    chk("R3", "user_rdy_b without monitor", rdy_b, 0);
    mon = 1'b1;
    tick(5);
    chk("R3", "user_rdy_b with monitor", rdy_b, 1);
  endtask

  task automatic t_usrclk();
    restart(1, 1, 1, 0, 0, 1);
    tick(50);
    chk("R4", "user_rdy_a w/o tx ready", rdy_a, 0);
    chk("R4", "user_rdy_b ignores tx", rdy_b, 1);
    txrdy = 1'b1;
    tick(5);
    chk("R4", "user_rdy_a with tx ready", rdy_a, 1);
  endtask

  task automatic t_phalign();
    restart(1, 1, 0, 0, 1, 1);
    wait_rdy_a();
    tick(5);
    chk("R5", "run_phalign_a", phal_a, 1);
    chk("R5", "run_phalign_b", phal_b, 0);
    phdone = 1'b1;
    tick(5);
    chk("R5", "run_phalign_a after done", phal_a, 0);
  endtask

  task automatic t_dv_window();
    int n = 0;
    restart(1, 1, 1, 0, 1, 1);
    wait_rdy_a();
    tick(10);
    dv = 1'b1;
    while (!done_a && n < 200) begin tick(1); n++; end
    chk_rng("R6", "dv->done cycles", n, 60, 65);
    chk("R6", "done_b", done_b, 1);
    chk("R6", "retry_a", retry_a, 0);
  endtask

  task automatic t_dv_drop();
    restart(1, 1, 1, 0, 1, 1);
    wait_rdy_a();
    tick(10);
    dv = 1'b1;
    tick(20);
    dv = 1'b0; lock = 1'b0;
    tick(6);
    chk("R7", "chan_rst_a", crst_a, 1);
    chk("R7", "done_a", done_a, 0);
    chk("R7", "retry_a", retry_a, 1);
  endtask

  task automatic t_timeout();
    restart(1, 0, 1, 0, 1, 1);
    wait_rdy_a();
    tick(90);
    chk("R8", "retry_a before timeout", retry_a, 0);
    tick(15);
    chk("R8", "retry_a after timeout", retry_a, 1);
    chk("R8", "user_rdy_a after timeout", rdy_a, 0);
  endtask

  task automatic t_saturate();
    restart(0, 1, 1, 0, 1, 1);
    tick(110);
    chk("R9", "retry_a first", retry_a, 1);
    tick(500);
    chk("R9", "retry_a saturated", retry_a, 3);
    chk("R9", "retry_b saturated", retry_b, 3);
  endtask

  task automatic t_refclk();
    restart(1, 1, 1, 1, 1, 1);
    for (int i = 0; i < 300 && !done_a; i++) tick(1);
    chk("R10", "done_a before loss", done_a, 1);
    lost = 1'b1;
    tick(4);
    chk("R10", "done_a", done_a, 0);
    chk("R10", "pll_reset_a", pllr_a, 1);
    chk("R10", "chan_rst_a", crst_a, 1);
    chk("R10", "done_b", done_b, 0);
    lost = 1'b0;
    for (int i = 0; i < 300 && !done_a; i++) tick(1);
    chk("R10", "done_a recovered", done_a, 1);
    chk("R10", "retry_a unchanged", retry_a, 0);
  endtask

  task automatic t_start();
    restart(0, 1, 1, 0, 1, 1);
    tick(110);
    chk("R11", "retry_a before start", retry_a, 1);
    start = 1'b1;
    tick(1);
    start = 1'b0;
    tick(2);
    chk("R11", "retry_a cleared", retry_a, 0);
    chk("R11", "chan_rst_a", crst_a, 1);
    chk("R11", "pll_reset_a", pllr_a, 1);
  endtask

  initial begin
    start = 0; lock = 0; lost = 0; rdone = 0; phdone = 0; dv = 0; txrdy = 0; mon = 0;
    t_reset_state();
    t_lock_gate();
    t_recclk();
    t_usrclk();
    t_phalign();
    t_dv_window();
    t_dv_drop();
    t_timeout();
    t_saturate();
    t_refclk();
    t_start();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule